// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The block collects a vector of level-sensitive interrupt sources into one raw level register. Two independent enable masks select which of the active sources drive the normal-priority output `irq_o` and which drive the fast-interrupt output `fiq_o`. Both outputs are registered. Each one is the OR-reduction of the raw level ANDed with its own mask.

Software programs each mask through a pair of registers. One register sets the bits written as 1 and the other clears them, so no read-modify-write is needed. Software can also raise and drop a soft interrupt on source line 0. A secondary instance can be cascaded by wiring its `irq_o` into one source line of a primary instance. The register interface is word-indexed: `addr` is a word index, not a byte offset. A read returns its data on `rdata` one cycle after `rd_en`.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both enable masks are 0, the soft interrupt is 0, and `irq_o`, `fiq_o` and `rdata` are 0.
- R2: The raw level register takes the value of `src_i` at each clock edge. Bit 0 is additionally ORed with the soft interrupt. Reads at index 1 and index 9 both return the raw level.
- R3: `irq_o` is 1 exactly when (raw level AND IRQ mask) is nonzero, and it changes one cycle after the source change or register write that caused the change.
- R4: `fiq_o` is 1 exactly when (raw level AND FIQ mask) is nonzero, with the same one-cycle timing.
- R5: A write at index 2 ORs `wdata` into the IRQ mask. A read at index 2 returns the IRQ mask.
- R6: A write at index 3 clears the IRQ mask bits where `wdata` is 1 and leaves the other bits unchanged.
- R7: A write at index 10 ORs `wdata` into the FIQ mask, and a write at index 11 clears the FIQ mask bits where `wdata` is 1. A read at index 10 returns the FIQ mask.
- R8: A write at index 4 with `wdata[0]`=1 sets the soft interrupt, and a write at index 5 with `wdata[0]`=1 clears it. Such a write with `wdata[0]`=0 does nothing. A read at index 4 returns raw level bit 0 in bit 0 and zeros in all other bits.
- R9: A read at index 0 returns (raw level AND IRQ mask). A read at index 8 returns (raw level AND FIQ mask).
- R10: Writes at indices 0, 1, 8, 9 and at any unmapped index change no state. Reads at indices 3, 5, 11 and at any unmapped index return 0.
- R11: `rdata` is registered. It holds the read result in the cycle after `rd_en`, and it is 0 in any cycle that follows a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word index |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Registered read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench checks the set/clear pairs for partial overlap, where only the addressed bits may move. A design that copied `wdata` instead of ORing it, or that cleared the whole mask, would lose neighbouring enable bits. It also exercises source line 0 with the soft interrupt and the hardware line each active on its own. A design that overwrote bit 0 with the soft bit, instead of ORing the two, would drop a hardware interrupt. Writes to the status indices and reads of the clear-only indices are then followed by mask readback and output checks. A decoder that aliased those indices would corrupt a mask or return stale data there.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int IDX_IRQ_STAT = 0;
  localparam int IDX_RAW_A    = 1;
  localparam int IDX_IRQ_SET  = 2;
  localparam int IDX_IRQ_CLR  = 3;
  localparam int IDX_SOFT_SET = 4;
  localparam int IDX_SOFT_CLR = 5;
  localparam int IDX_FIQ_STAT = 8;
  localparam int IDX_RAW_B    = 9;
  localparam int IDX_FIQ_SET  = 10;
  localparam int IDX_FIQ_CLR  = 11;
  localparam int NUM_OUTS     = 2;
endpackage

// File: rtl/dic_level_capture.sv
module dic_level_capture #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   raw_d,
  output logic [NSRC-1:0]   raw_q
);
  import dic_pkg::*;

  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(IDX_SOFT_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(IDX_SOFT_CLR);

  logic soft_q;
  logic soft_d;

  always_comb begin
    soft_d = soft_q;
    if (wr_en && addr == A_SET && wdata[0]) soft_d = 1'b1;
    else if (wr_en && addr == A_CLR && wdata[0]) soft_d = 1'b0;
  end

  always_comb begin
    raw_d    = src_i;
    raw_d[0] = src_i[0] | soft_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      soft_q <= soft_d;
      raw_q  <= raw_d;
    end
  end
endmodule

// File: rtl/dic_mask_reg.sv
module dic_mask_reg #(
  parameter int NSRC    = 32,
  parameter int ADDR_W  = 4,
  parameter int SET_IDX = 2,
  parameter int CLR_IDX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   en_d,
  output logic [NSRC-1:0]   en_q
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(SET_IDX);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_IDX);

  always_comb begin
    en_d = en_q;
    if (wr_en && addr == A_SET) en_d = en_q | wdata;
    else if (wr_en && addr == A_CLR) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/dic_read_mux.sv
module dic_read_mux #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   raw_q,
  input  logic [NSRC-1:0]   irq_en_q,
  input  logic [NSRC-1:0]   fiq_en_q,
  output logic [NSRC-1:0]   rdata
);
  import dic_pkg::*;

  logic [NSRC-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(IDX_IRQ_STAT))      rd_d = raw_q & irq_en_q;
      else if (addr == ADDR_W'(IDX_RAW_A))    rd_d = raw_q;
      else if (addr == ADDR_W'(IDX_IRQ_SET))  rd_d = irq_en_q;
      else if (addr == ADDR_W'(IDX_SOFT_SET)) rd_d[0] = raw_q[0];
      else if (addr == ADDR_W'(IDX_FIQ_STAT)) rd_d = raw_q & fiq_en_q;
      else if (addr == ADDR_W'(IDX_RAW_B))    rd_d = raw_q;
      else if (addr == ADDR_W'(IDX_FIQ_SET))  rd_d = fiq_en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  import dic_pkg::*;

  logic [NSRC-1:0] raw_d, raw_q;
  logic [NUM_OUTS-1:0][NSRC-1:0] en_d, en_q;
  logic [NSRC-1:0] irq_en_q, fiq_en_q;
  logic [NUM_OUTS-1:0] out_q;

  dic_level_capture #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .raw_d(raw_d), .raw_q(raw_q)
  );

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_mask
    dic_mask_reg #(
      .NSRC(NSRC), .ADDR_W(ADDR_W),
      .SET_IDX(g == 0 ? IDX_IRQ_SET : IDX_FIQ_SET),
      .CLR_IDX(g == 0 ? IDX_IRQ_CLR : IDX_FIQ_CLR)
    ) u_mask (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .en_d(en_d[g]), .en_q(en_q[g])
    );

    always_ff @(posedge clk) begin
      if (rst) out_q[g] <= 1'b0;
      else     out_q[g] <= |(raw_d & en_d[g]);
    end
  end

  assign irq_en_q = en_q[0];
  assign fiq_en_q = en_q[1];
  assign irq_o    = out_q[0];
  assign fiq_o    = out_q[1];

  dic_read_mux #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .raw_q(raw_q),
    .irq_en_q(irq_en_q), .fiq_en_q(fiq_en_q), .rdata(rdata)
  );
endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   irq_en_q,
  input logic [NSRC-1:0]   fiq_en_q
);
  // R2
  raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
    raw_q[NSRC-1:1] == $past(src_i[NSRC-1:1]));
  // R3
  irq_out_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(raw_q & irq_en_q)));
  // R4
  fiq_out_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o == (|(raw_q & fiq_en_q)));
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2)) |=> ((irq_en_q & $past(wdata)) == $past(wdata)));
  // R6
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(3)) |=> ((irq_en_q & $past(wdata)) == '0));
  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(1) || addr == ADDR_W'(9)))
      |=> ($stable(irq_en_q) && $stable(fiq_en_q)));
  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

bind dual_irq_ctrl dic_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .raw_q(raw_q), .irq_en_q(irq_en_q), .fiq_en_q(fiq_en_q)
);

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
  localparam int NSRC = 32;
  localparam int ADDR_W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [NSRC-1:0] rdata;
  logic irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [NSRC-1:0] m_ien = '0, m_fen = '0;
  logic m_soft = 1'b0;

  logic [NSRC-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) i_dual_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [NSRC-1:0] m_lvl();
    logic [NSRC-1:0] l;
    l = src_i;
    l[0] = src_i[0] | m_soft;
    return l;
  endfunction

  task automatic check(input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    check({31'b0, irq_o}, {31'b0, |(m_lvl() & m_ien)}, {tag, " irq_o"});
    check({31'b0, fiq_o}, {31'b0, |(m_lvl() & m_fen)}, {tag, " fiq_o"});
  endtask

  task automatic wr(input int idx, input logic [NSRC-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(idx); wdata = v;
    case (idx)
      2: m_ien = m_ien | v;
      3: m_ien = m_ien & ~v;
      4: if (v[0]) m_soft = 1'b1;
      5: if (v[0]) m_soft = 1'b0;
      10: m_fen = m_fen | v;
      11: m_fen = m_fen & ~v;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_src(input logic [NSRC-1:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic rd(input int idx, input logic [NSRC-1:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(idx);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read data as results appear
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) check(rdata, '0, "R11 unexpected read");
        else check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rdata, '0, "R1 rdata");
    chk_out("R1");
    rd(2, '0, "R1 irq mask");
    rd(10, '0, "R1 fiq mask");
    rd(4, '0, "R1 soft");

    // R2 raw capture
    set_src(32'h0000_0F00);
    chk_out("R2 masked");
    rd(1, 32'h0000_0F00, "R2 raw idx1");
    rd(9, 32'h0000_0F00, "R2 raw idx9");
    @(negedge clk);
    check(rdata, '0, "R11 idle rdata");

    // R5 / R3
    wr(2, 32'h0000_0300);
    chk_out("R3 enable");
    check({31'b0, irq_o}, 32'd1, "R3 irq high");
    wr(2, 32'h0000_0001);
    rd(2, 32'h0000_0301, "R5 or-set");
    // R6
    wr(3, 32'h0000_0100);
    rd(2, 32'h0000_0201, "R6 partial clear");
    chk_out("R6 still active");
    wr(3, 32'h0000_0200);
    check({31'b0, irq_o}, 32'd0, "R3 irq low");
    chk_out("R6");

    // R7 / R4 / R9
    wr(10, 32'h0000_0810);
    check({31'b0, fiq_o}, 32'd1, "R4 fiq high");
    rd(10, 32'h0000_0810, "R7 fiq mask");
    rd(8, 32'h0000_0800, "R9 fiq status");
    rd(0, 32'h0000_0000, "R9 irq status");

    // R8 soft interrupt
    wr(4, 32'h0000_0000);
    rd(4, 32'h0, "R8 zero bit no set");
    wr(4, 32'hFFFF_FFFF);
    check({31'b0, irq_o}, 32'd1, "R8 soft raises irq");
    rd(4, 32'h1, "R8 soft read");
    rd(0, 32'h1, "R9 irq status soft");
    wr(5, 32'h0000_0000);
    chk_out("R8 clr zero bit");
    wr(5, 32'h0000_0001);
    check({31'b0, irq_o}, 32'd0, "R8 soft cleared");
    set_src(32'h0000_0F01);
    rd(4, 32'h1, "R8 hw line0 via or");
    chk_out("R8 hw line0");
    wr(4, 32'h1);
    set_src(32'h0000_0F00);
    rd(1, 32'h0000_0F01, "R8 soft holds bit0");
    wr(5, 32'h1);
    chk_out("R8");

    // R10 invalid accesses
    wr(0, '1); wr(1, '1); wr(8, '1); wr(9, '1); wr(13, '1);
    rd(2, m_ien, "R10 irq mask kept");
    rd(10, m_fen, "R10 fiq mask kept");
    rd(4, 32'h0, "R10 soft kept");
    chk_out("R10 outputs kept");
    rd(3, '0, "R10 read idx3");
    rd(5, '0, "R10 read idx5");
    rd(11, '0, "R10 read idx11");
    rd(14, '0, "R10 read unmapped");

    // R7 clear, then pattern sweep for R3/R4
    wr(11, 32'h0000_0800);
    rd(10, 32'h0000_0010, "R7 fiq clear");
    wr(2, 32'hA000_0000);
    for (int i = 0; i < 8; i++) begin
      set_src(32'h1 << (i * 4 + 1) | (i[0] ? 32'h8000_0000 : 32'h0));
      chk_out("R3 R4 sweep");
      rd(0, m_lvl() & m_ien, "R9 sweep irq status");
      rd(8, m_lvl() & m_fen, "R9 sweep fiq status");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule